// File: doc/BRIEF.md
# SD Host Wrapper Register Block

This block is the 32-bit register front end for a pair (or a single instance) of SD host slot controllers. It decodes a 4 KiB access window. The lowest 256 bytes hold the wrapper's own words:

- a global info word that flags which slots are fitted and carries a self-clearing reset bit;
- a debounce word, a bus word, a write-protect polarity word and a card-detect word;
- a read-only interrupt status word;
- per-slot copies of the capability and maximum-current words.

The next 256-byte pages are forwarded to the slot controllers, one page per slot, through a simple select/address/data port.

Each slot drives a level interrupt into the block. The block registers these levels into the status word and ORs them into one combined interrupt line. The capability and maximum-current copies are also driven out on ports, so that the slot logic can use the values software programmed. Accesses must be full 32-bit and word aligned. An access that is not, or that falls outside every mapped region, is ignored and flagged with an error on its response.

Top module: `sdwrap_regs`

## Requirements
- R1: After reset, every wrapper word reads 0 except the following. Word 0x00 holds bit 16 set, and bit 17 set when two slots are configured. Word 0x04 holds 0x00000005. The capability words (0x10, and 0x20 when two slots are configured) hold CAP_DEFAULT. The combined interrupt output is low.
- R2: A write to word 0x00 stores the written value with bit 0 forced to 0, so bit 0 always reads back as 0.
- R3: Every other wrapper word from 0x00 to 0xF8 is plain 32-bit read/write storage.
- R4: Words 0x10 and 0x18 are slot 0's capability and maximum-current words, and words 0x20 and 0x28 are slot 1's. They appear on capWord and maxCurrWord at bits [32n+31:32n] for slot n.
- R5: Bit n of word 0xFC reads the level slotIrq[n] had one clock earlier. Its bits above the slot count read 0, and writes to it have no effect.
- R6: irqOut is high one clock after any slotIrq bit is high. One slot dropping its level leaves irqOut high while another slot still asserts.
- R7: An access to address (n+1)*0x100 + k, with 0 <= k < 0x100, raises slotSel[n] in the same cycle. slotAddr is k, and slotWrite and slotWdata follow the request. A read returns that slot's slotRdata in the response. Wrapper storage is unchanged.
- R8: An address at or above (NUM_SLOTS+1)*0x100 returns read data 0 with rspErr set. A write to such an address changes nothing.
- R9: A request whose byte enables are not all four set, or whose address bits [1:0] are not 0, is ignored. It selects no slot, returns data 0 and sets rspErr.
- R10: Every request gets rspValid exactly one cycle after it is presented, and an idle cycle gives no response. The data of a write response is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address in the 4 KiB window |
| reqBe | input | 4 | Byte enables, all four required |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspData | output | 32 | Read data |
| rspErr | output | 1 | Request was ignored as illegal or unmapped |
| slotIrq | input | NUM_SLOTS | Per-slot interrupt levels |
| irqOut | output | 1 | Combined interrupt |
| slotSel | output | NUM_SLOTS | Slot window select |
| slotWrite | output | 1 | Slot access is a write |
| slotAddr | output | 8 | Byte offset inside the slot window |
| slotWdata | output | 32 | Slot write data |
| slotRdata | input | 32*NUM_SLOTS | Slot read data, slot n at [32n+31:32n] |
| capWord | output | 32*NUM_SLOTS | Capability word copies |
| maxCurrWord | output | 32*NUM_SLOTS | Maximum-current word copies |

## Verification
The bench builds the block with NUM_SLOTS = 2 and CAP_DEFAULT = 0x01E80080. With two slots, both slot windows and both shadow pairs can be exercised, as well as the case where one interrupt falls while the other stays high. With these values, all 64 wrapper words can be swept for reset values and for write/readback. Every 256-byte page above the slot windows is probed for zero reads and ignored writes. A final sweep of the whole wrapper shows that no slot, unmapped or malformed access disturbed the wrapper storage.

// File: rtl/sdwrap_pkg.sv
package sdwrap_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 12;
  localparam int PAGE_W      = 8;
  localparam int WORD_IDX_W  = PAGE_W - 2;
  localparam int REG_WORDS   = 1 << WORD_IDX_W;
  localparam int INFO_IDX    = 0;
  localparam int DEBOUNCE_IDX = 1;
  localparam int STAT_IDX    = REG_WORDS - 1;
  localparam int CAP_BASE_IDX = 4;
  localparam int MAXC_BASE_IDX = 6;
  localparam int SLOT_STRIDE_IDX = 4;
  localparam int PRESENT_BIT = 16;
  localparam logic [DATA_W-1:0] DEBOUNCE_RST = 32'h0000_0005;

  typedef struct packed {
    logic                  wrEn;
    logic                  rdEn;
    logic                  slotRdEn;
    logic                  slotIdx;
    logic                  bad;
    logic [WORD_IDX_W-1:0] wordIdx;
  } strobe_t;
endpackage

// File: rtl/sdwrap_ctrl.sv
module sdwrap_ctrl
  import sdwrap_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [3:0]           reqBe,
  output strobe_t              strobe,
  output logic [NUM_SLOTS-1:0] slotSel,
  output logic                 rspValid,
  output logic                 rspErr
);
  localparam int PAGE_HI_W = ADDR_W - PAGE_W;

  logic [PAGE_HI_W-1:0] page;
  logic                 wellFormed;
  logic                 legal;
  logic                 inRegs;
  logic [NUM_SLOTS-1:0] pageHit;
  logic                 anySlot;
  logic                 slotIdxC;

  assign page       = reqAddr[ADDR_W-1:PAGE_W];
  assign wellFormed = (reqBe == 4'hF) && (reqAddr[1:0] == 2'b00);
  assign legal      = reqValid && wellFormed;
  assign inRegs     = (page == '0);

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_hit
    assign pageHit[n] = (page == PAGE_HI_W'(n + 1));
  end

  assign anySlot = |pageHit;
  assign slotSel = legal ? pageHit : '0;

  always_comb begin
    slotIdxC = 1'b0;
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (pageHit[n]) slotIdxC = n[0];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = legal && reqWrite && inRegs;
    strobe.rdEn     = legal && !reqWrite && inRegs;
    strobe.slotRdEn = legal && !reqWrite && anySlot;
    strobe.slotIdx  = slotIdxC;
    strobe.bad      = reqValid && !(wellFormed && (inRegs || anySlot));
    strobe.wordIdx  = reqAddr[PAGE_W-1:2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= strobe.bad;
    end
  end

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel)) else $error("slot selects overlap"); // R7
  AST_MALFORMED_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqBe != 4'hF) |-> (slotSel == '0)) else $error("malformed access reached a slot"); // R9
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid) else $error("response missing"); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid) else $error("response without request"); // R10
endmodule

// File: rtl/sdwrap_datapath.sv
module sdwrap_datapath
  import sdwrap_pkg::*;
#(
  parameter int                NUM_SLOTS   = 2,
  parameter logic [DATA_W-1:0] CAP_DEFAULT = 32'h01E8_0080
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_SLOTS-1:0]          slotIrq,
  input  logic [NUM_SLOTS*DATA_W-1:0]   slotRdata,
  output logic [DATA_W-1:0]             rspData,
  output logic                          irqOut,
  output logic [NUM_SLOTS*DATA_W-1:0]   capWord,
  output logic [NUM_SLOTS*DATA_W-1:0]   maxCurrWord
);
  function automatic logic [DATA_W-1:0] rstVal(int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == INFO_IDX) begin
      for (int n = 0; n < NUM_SLOTS; n++) v[PRESENT_BIT + n] = 1'b1;
    end else if (idx == DEBOUNCE_IDX) begin
      v = DEBOUNCE_RST;
    end else begin
      for (int n = 0; n < NUM_SLOTS; n++)
        if (idx == CAP_BASE_IDX + SLOT_STRIDE_IDX * n) v = CAP_DEFAULT;
    end
    return v;
  endfunction

  logic [DATA_W-1:0]    wordQ [REG_WORDS];
  logic [NUM_SLOTS-1:0] irqQ;
  logic [DATA_W-1:0]    slotRd;
  logic [DATA_W-1:0]    rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= '0;
    else       irqQ <= slotIrq;
  end

  assign irqOut = |irqQ;

  for (genvar i = 0; i < REG_WORDS; i++) begin : g_word
    if (i == STAT_IDX) begin : g_stat
      assign wordQ[i] = {{(DATA_W-NUM_SLOTS){1'b0}}, irqQ};
    end else begin : g_store
      localparam logic [DATA_W-1:0] RST = rstVal(i);
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = strobe.wrEn && (strobe.wordIdx == WORD_IDX_W'(i));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= RST;
        end else if (hit) begin
          if (i == INFO_IDX) q <= wdata & ~DATA_W'(1);
          else               q <= wdata;
        end
      end
      assign wordQ[i] = q;
    end
  end

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_shadow
    assign capWord[n*DATA_W +: DATA_W]     = wordQ[CAP_BASE_IDX + SLOT_STRIDE_IDX * n];
    assign maxCurrWord[n*DATA_W +: DATA_W] = wordQ[MAXC_BASE_IDX + SLOT_STRIDE_IDX * n];
  end

  always_comb begin
    slotRd = '0;
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (strobe.slotIdx == n[0]) slotRd = slotRdata[n*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (strobe.rdEn)          rdNext = wordQ[strobe.wordIdx];
    else if (strobe.slotRdEn) rdNext = slotRd;
    else                      rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspData <= '0;
    else       rspData <= rdNext;
  end

  AST_INFO_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.wordIdx == WORD_IDX_W'(INFO_IDX)) |=> !rspData[0]) else $error("reset bit read as one"); // R2
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.wordIdx == WORD_IDX_W'(STAT_IDX)) |=>
      (rspData == {{(DATA_W-NUM_SLOTS){1'b0}}, $past(slotIrq, 2)})) else $error("status not mirroring levels"); // R5
  AST_IRQ_COMBINED: assert property (@(posedge clk) disable iff (!rstN)
    (|slotIrq) |=> irqOut) else $error("combined interrupt missed"); // R6
  AST_BAD_NO_SHADOW_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bad |=> ($stable(capWord) && $stable(maxCurrWord))) else $error("bad access changed a shadow"); // R9
endmodule

// File: rtl/sdwrap_regs.sv
module sdwrap_regs
  import sdwrap_pkg::*;
#(
  parameter int                NUM_SLOTS   = 2,
  parameter logic [DATA_W-1:0] CAP_DEFAULT = 32'h01E8_0080
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [11:0]                 reqAddr,
  input  logic [3:0]                  reqBe,
  input  logic [31:0]                 reqWdata,
  output logic                        rspValid,
  output logic [31:0]                 rspData,
  output logic                        rspErr,
  input  logic [NUM_SLOTS-1:0]        slotIrq,
  output logic                        irqOut,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic                        slotWrite,
  output logic [7:0]                  slotAddr,
  output logic [31:0]                 slotWdata,
  input  logic [NUM_SLOTS*32-1:0]     slotRdata,
  output logic [NUM_SLOTS*32-1:0]     capWord,
  output logic [NUM_SLOTS*32-1:0]     maxCurrWord
);
  strobe_t strobe;

  initial begin
    if (NUM_SLOTS < 1 || NUM_SLOTS > 2) $error("NUM_SLOTS must be 1 or 2");
  end

  sdwrap_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .strobe(strobe), .slotSel(slotSel),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  sdwrap_datapath #(.NUM_SLOTS(NUM_SLOTS), .CAP_DEFAULT(CAP_DEFAULT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(reqWdata),
    .slotIrq(slotIrq), .slotRdata(slotRdata), .rspData(rspData),
    .irqOut(irqOut), .capWord(capWord), .maxCurrWord(maxCurrWord)
  );

  assign slotWrite = reqWrite;
  assign slotAddr  = reqAddr[PAGE_W-1:0];
  assign slotWdata = reqWdata;
endmodule

// File: tb/tb_sdwrap_regs.sv
module tb_sdwrap_regs;
  localparam int          NS  = 2;
  localparam logic [31:0] CAP = 32'h01E8_0080;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid, rspErr, irqOut, slotWrite;
  logic [31:0] rspData, slotWdata;
  logic [NS-1:0] slotIrq = '0, slotSel;
  logic [7:0] slotAddr;
  logic [NS*32-1:0] slotRdata, capWord, maxCurrWord;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] model [64];

  always #2.5 clk = ~clk;

  assign slotRdata = {8'hC1, 16'h0000, slotAddr, 8'hC0, 16'h0000, slotAddr};

  sdwrap_regs #(.NUM_SLOTS(NS), .CAP_DEFAULT(CAP)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .slotIrq(slotIrq), .irqOut(irqOut), .slotSel(slotSel),
    .slotWrite(slotWrite), .slotAddr(slotAddr), .slotWdata(slotWdata),
    .slotRdata(slotRdata), .capWord(capWord), .maxCurrWord(maxCurrWord)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rstExp(int i);
    if (i == 0)  return 32'h0003_0000;
    if (i == 1)  return 32'h5;
    if (i == 4 || i == 8) return CAP;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(int i);
    return {8'(i), 8'(~i), 8'(i * 3 + 1), 8'(i ^ 8'h5B)};
  endfunction

  logic [31:0] aRd; logic aErr, aWr; logic [NS-1:0] aSel; logic [7:0] aSa; logic [31:0] aWd;

  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqBe = be;
    #1;
    aSel = slotSel; aSa = slotAddr; aWr = slotWrite; aWd = slotWdata;
    @(negedge clk);
    reqValid = 1'b0;
    aRd = rspData; aErr = rspErr;
    chk(rspValid == 1'b1, "R10 rspValid", 64'(rspValid), 64'd1);
    if (wr) chk(rspData == 32'h0, "R10 write data", 64'(rspData), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rspValid == 1'b0, "R1 rspValid", 64'(rspValid), 0);
    chk(irqOut == 1'b0, "R1 irqOut", 64'(irqOut), 0);
    chk(capWord == {CAP, CAP}, "R1 capWord", 64'(capWord), 64'({CAP, CAP}));
    chk(maxCurrWord == '0, "R1 maxCurrWord", 64'(maxCurrWord), 0);
    @(negedge clk);
    chk(rspValid == 1'b0, "R10 idle", 64'(rspValid), 0);

    for (int i = 0; i < 64; i++) begin
      acc(1'b0, 12'(i * 4), 32'h0, 4'hF);
      chk(aRd == rstExp(i) && !aErr, $sformatf("R1 word %0d", i), 64'(aRd), 64'(rstExp(i)));
    end

    for (int i = 0; i < 64; i++) begin
      acc(1'b1, 12'(i * 4), pat(i), 4'hF);
      if (i == 0)       model[i] = pat(i) & ~32'h1;
      else if (i == 63) model[i] = 32'h0;
      else              model[i] = pat(i);
    end
    for (int i = 0; i < 64; i++) begin
      acc(1'b0, 12'(i * 4), 32'h0, 4'hF);
      if (i == 0)       chk(aRd == model[i], "R2 info readback", 64'(aRd), 64'(model[i]));
      else if (i == 63) chk(aRd == 32'h0, "R5 status write ignored", 64'(aRd), 0);
      else if (i == 4 || i == 6 || i == 8 || i == 10)
                        chk(aRd == model[i], $sformatf("R4 shadow %0d", i), 64'(aRd), 64'(model[i]));
      else              chk(aRd == model[i], $sformatf("R3 word %0d", i), 64'(aRd), 64'(model[i]));
    end
    chk(capWord == {model[8], model[4]}, "R4 capWord port", 64'(capWord), 64'({model[8], model[4]}));
    chk(maxCurrWord == {model[10], model[6]}, "R4 maxCurrWord port", 64'(maxCurrWord), 64'({model[10], model[6]}));

    acc(1'b1, 12'h000, 32'hFFFF_FFFF, 4'hF);
    model[0] = 32'hFFFF_FFFE;
    acc(1'b0, 12'h000, 32'h0, 4'hF);
    chk(aRd == 32'hFFFF_FFFE, "R2 all-ones info", 64'(aRd), 64'hFFFF_FFFE);

    begin
      logic [1:0] seq [5] = '{2'b01, 2'b11, 2'b10, 2'b00, 2'b10};
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        slotIrq = seq[k];
        @(negedge clk);
        chk(irqOut == (|seq[k]), $sformatf("R6 irqOut step %0d", k), 64'(irqOut), 64'(|seq[k]));
        acc(1'b0, 12'hFC, 32'h0, 4'hF);
        chk(aRd == {30'h0, seq[k]}, $sformatf("R5 status step %0d", k), 64'(aRd), 64'(seq[k]));
      end
      @(negedge clk);
      slotIrq = '0;
      @(negedge clk);
      chk(irqOut == 1'b0, "R6 irqOut cleared", 64'(irqOut), 0);
    end

    for (int n = 0; n < NS; n++) begin
      logic [7:0] offs [4] = '{8'h00, 8'h04, 8'h80, 8'hFC};
      for (int k = 0; k < 4; k++) begin
        logic [11:0] a;
        logic [31:0] wd;
        a = 12'((n + 1) * 256) + 12'(offs[k]);
        wd = 32'hDEAD_0000 | 32'(a);
        acc(1'b1, a, wd, 4'hF);
        chk(aSel == NS'(1 << n) && aSa == offs[k] && aWr && aWd == wd,
            $sformatf("R7 slot%0d write sel/addr", n), 64'({aSel, aSa, aWr}), 64'({NS'(1 << n), offs[k], 1'b1}));
        acc(1'b0, a, 32'h0, 4'hF);
        chk(aRd == {8'(8'hC0 + n), 16'h0, offs[k]} && !aErr, $sformatf("R7 slot%0d read", n),
            64'(aRd), 64'({8'(8'hC0 + n), 16'h0, offs[k]}));
      end
    end

    for (int p = NS + 1; p < 16; p++) begin
      logic [11:0] a;
      a = 12'(p * 256) + 12'((p * 20) & 8'hFC);
      acc(1'b1, a, 32'hFFFF_FFFF, 4'hF);
      chk(aErr && aSel == '0, $sformatf("R8 unmapped write page %0d", p), 64'({aErr, aSel}), 64'({1'b1, NS'(0)}));
      acc(1'b0, a, 32'h0, 4'hF);
      chk(aRd == 32'h0 && aErr, $sformatf("R8 unmapped read page %0d", p), 64'(aRd), 0);
    end

    acc(1'b1, 12'h008, 32'h1234_5678, 4'h7);
    chk(aErr && aSel == '0, "R9 partial byte enables", 64'(aErr), 1);
    acc(1'b1, 12'h012, 32'h1234_5678, 4'hF);
    chk(aErr, "R9 misaligned write", 64'(aErr), 1);
    acc(1'b0, 12'h104, 32'h0, 4'h0);
    chk(aErr && aSel == '0 && aRd == 32'h0, "R9 malformed slot read", 64'({aErr, aSel, aRd}), 64'({1'b1, NS'(0), 32'h0}));
    acc(1'b0, 12'h009, 32'h0, 4'hF);
    chk(aErr && aRd == 32'h0, "R9 misaligned read", 64'(aRd), 0);

    for (int i = 0; i < 63; i++) begin
      acc(1'b0, 12'(i * 4), 32'h0, 4'hF);
      chk(aRd == model[i], $sformatf("R8 storage kept word %0d", i), 64'(aRd), 64'(model[i]));
    end
    chk(capWord == {model[8], model[4]}, "R9 shadow kept", 64'(capWord), 64'({model[8], model[4]}));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule